// File: doc/BRIEF.md
# E1 Frame Timeslot Sequencer

This block runs on the 2.048 MHz line bit clock and keeps track of where the current bit sits within the E1 frame and multiframe. Each frame lasts 125 µs and holds 32 timeslots of 8 bits. The most significant bit of a timeslot is sent first. A multiframe groups 16 frames and lasts 2.0 ms. On every bit clock the block reports four positions: the bit number within the timeslot (1 to 8), the timeslot number, the frame number within the multiframe, and the voice/data channel that the timeslot carries.

Timeslot 0 (framing) and timeslot 16 (signalling) carry no channel. The channels are therefore numbered non-linearly: timeslots 1 to 15 carry channels 1 to 15, and timeslots 17 to 31 carry channels 16 to 30. The block also gives single-cycle frame-start and multiframe-start strobes and level flags for the framing and signalling timeslots. Neighbouring logic, such as alignment detection or signalling extraction, uses these signals as its time base. A synchronous reset, or a realign pulse from an alignment detector, puts the sequencer back at the start of frame 0.

Top module: `e1_slot_seq`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the position after that edge is bit 1, timeslot 0, frame 0.
- R2: `bitNum` steps 1,2,...,8 on successive clocks and then returns to 1. The timeslot number changes only on the clock that follows bit 8.
- R3: `slotNum` steps 0 to 31 and then wraps to 0. The frame number changes only when timeslot 31 bit 8 is left.
- R4: `frameNum` steps 0 to 15 and then wraps to 0, which gives 4096 bit clocks per multiframe.
- R5: During timeslots 1 to 15, `chanValid` is 1 and `chanNum` equals the timeslot number.
- R6: During timeslots 17 to 31, `chanValid` is 1 and `chanNum` equals the timeslot number minus 1 (channels 16 to 30).
- R7: During timeslots 0 and 16, `chanValid` is 0 and `chanNum` reads 0.
- R8: `frameStart` is 1 exactly in the cycle at bit 1 of timeslot 0, in every frame.
- R9: `mfStart` is 1 exactly in the cycle at bit 1 of timeslot 0 of frame 0.
- R10: `alignSlot` is 1 for all 8 bits of timeslot 0, and `sigSlot` is 1 for all 8 bits of timeslot 16. Each is 0 at all other times.
- R11: A `realign` sampled high at a clock edge makes the next position bit 1, timeslot 0, frame 0, whatever the previous position was. Counting then resumes from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.048 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| realign | input | 1 | Synchronous load to the start of frame 0 |
| bitNum | output | 4 | Bit within the timeslot, 1 (MSB) to 8 (LSB) |
| slotNum | output | 5 | Timeslot number, 0 to 31 |
| frameNum | output | 4 | Frame within the multiframe, 0 to 15 |
| chanNum | output | 5 | Voice/data channel, 1 to 30, or 0 when there is none |
| chanValid | output | 1 | High when the current timeslot carries a channel |
| frameStart | output | 1 | One-cycle strobe at bit 1 of timeslot 0 |
| mfStart | output | 1 | One-cycle strobe at bit 1 of timeslot 0 of frame 0 |
| alignSlot | output | 1 | High during timeslot 0 |
| sigSlot | output | 1 | High during timeslot 16 |

## Verification
Every output is decoded directly from three counters, so a wrong bit count shows up on `bitNum` in the same cycle. A wrong carry into the timeslot or frame counter cannot stay hidden, but it only shows when that counter next moves. For the timeslot counter that is within 8 clocks. For the frame counter it can take up to 256 clocks, and the multiframe strobe may not show the error for up to 4096 clocks. The bench therefore walks more than one full multiframe and compares every cycle against a position model. It also checks the fixed table entries at the channel-map edges (timeslots 15, 16, 17 and 31) and the frame and multiframe wraps.

// File: rtl/e1_seq_pkg.sv
package e1_seq_pkg;
  // Strobes that the control sends to the counting datapath
  typedef struct packed {
    logic clear;     // load the start of frame 0
    logic bitAdv;    // advance the bit counter
    logic slotAdv;   // advance the timeslot counter
    logic frameAdv;  // advance the frame counter
  } seqStrb_t;
endpackage

// File: rtl/e1_seq_ctrl.sv
module e1_seq_ctrl
  import e1_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     realign,
  input  logic     bitLast,
  input  logic     slotLast,
  output seqStrb_t strb
);

  always_comb begin
    strb.clear    = rst | realign;
    strb.bitAdv   = ~strb.clear;
    strb.slotAdv  = ~strb.clear & bitLast;
    strb.frameAdv = ~strb.clear & bitLast & slotLast;
  end

  // R11: clear has priority; no advance strobe accompanies it
  a_r11_clear_exclusive: assert property (@(posedge clk)
    (rst | realign) |-> !(strb.bitAdv | strb.slotAdv | strb.frameAdv));

  // R3: a frame step always coincides with a timeslot step
  a_r3_frame_needs_slot: assert property (@(posedge clk) disable iff (rst)
    strb.frameAdv |-> strb.slotAdv);

endmodule

// File: rtl/e1_seq_datapath.sv
module e1_seq_datapath
  import e1_seq_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int SLOTS_PER_FRAME = 32,
  parameter int FRAMES_PER_MF = 16,
  parameter int SIG_SLOT = 16,
  localparam int BCW = $clog2(BITS_PER_SLOT),
  localparam int BNW = $clog2(BITS_PER_SLOT + 1),
  localparam int SW  = $clog2(SLOTS_PER_FRAME),
  localparam int FW  = $clog2(FRAMES_PER_MF)
) (
  input  logic           clk,
  input  logic           rst,
  input  seqStrb_t       strb,
  output logic           bitLast,
  output logic           slotLast,
  output logic [BNW-1:0] bitNum,
  output logic [SW-1:0]  slotNum,
  output logic [FW-1:0]  frameNum,
  output logic [SW-1:0]  chanNum,
  output logic           chanValid,
  output logic           frameStart,
  output logic           mfStart,
  output logic           alignSlot,
  output logic           sigSlot
);

  logic [BCW-1:0] bitCnt;
  logic [SW-1:0]  slotCnt;
  logic [FW-1:0]  frameCnt;
  logic           frameLast;

  assign bitLast   = (bitCnt == BCW'(BITS_PER_SLOT - 1));
  assign slotLast  = (slotCnt == SW'(SLOTS_PER_FRAME - 1));
  assign frameLast = (frameCnt == FW'(FRAMES_PER_MF - 1));

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      bitCnt   <= '0;
      slotCnt  <= '0;
      frameCnt <= '0;
    end else begin
      if (strb.bitAdv)   bitCnt   <= bitLast   ? '0 : bitCnt + BCW'(1);
      if (strb.slotAdv)  slotCnt  <= slotLast  ? '0 : slotCnt + SW'(1);
      if (strb.frameAdv) frameCnt <= frameLast ? '0 : frameCnt + FW'(1);
    end
  end

  // Position outputs
  assign bitNum   = BNW'(bitCnt) + BNW'(1);
  assign slotNum  = slotCnt;
  assign frameNum = frameCnt;

  assign alignSlot  = (slotCnt == '0);
  assign sigSlot    = (slotCnt == SW'(SIG_SLOT));
  assign frameStart = alignSlot && (bitCnt == '0);
  assign mfStart    = frameStart && (frameCnt == '0);

  // Timeslot to channel map: skip framing and signalling slots
  always_comb begin
    if (alignSlot || sigSlot) begin
      chanValid = 1'b0;
      chanNum   = '0;
    end else if (slotCnt < SW'(SIG_SLOT)) begin
      chanValid = 1'b1;
      chanNum   = slotCnt;
    end else begin
      chanValid = 1'b1;
      chanNum   = slotCnt - SW'(1);
    end
  end

  // R11 / R1: a clear lands on the start position
  a_r11_clear_to_start: assert property (@(posedge clk)
    strb.clear |=> (bitCnt == '0 && slotCnt == '0 && frameCnt == '0));

  // R2: the timeslot holds while bits remain in it
  a_r2_slot_holds: assert property (@(posedge clk) disable iff (rst)
    (strb.bitAdv && !bitLast) |=> $stable(slotCnt));

  // R3: the frame holds while timeslots remain in it
  a_r3_frame_holds: assert property (@(posedge clk) disable iff (rst)
    (strb.bitAdv && !(bitLast && slotLast)) |=> $stable(frameCnt));

  // R7: no channel means channel number zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !chanValid |-> (chanNum == '0));

  // R9: multiframe strobe only ever with frame strobe
  a_r9_mf_in_frame: assert property (@(posedge clk) disable iff (rst)
    mfStart |-> frameStart);

  // R10: framing and signalling flags never overlap
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({alignSlot, sigSlot}));

  // R8: frame strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (frameStart && strb.bitAdv) |=> !frameStart);

endmodule

// File: rtl/e1_slot_seq.sv
module e1_slot_seq
  import e1_seq_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int SLOTS_PER_FRAME = 32,
  parameter int FRAMES_PER_MF = 16,
  parameter int SIG_SLOT = 16,
  localparam int BNW = $clog2(BITS_PER_SLOT + 1),
  localparam int SW  = $clog2(SLOTS_PER_FRAME),
  localparam int FW  = $clog2(FRAMES_PER_MF)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           realign,
  output logic [BNW-1:0] bitNum,
  output logic [SW-1:0]  slotNum,
  output logic [FW-1:0]  frameNum,
  output logic [SW-1:0]  chanNum,
  output logic           chanValid,
  output logic           frameStart,
  output logic           mfStart,
  output logic           alignSlot,
  output logic           sigSlot
);

  seqStrb_t strb;
  logic     bitLast;
  logic     slotLast;

  e1_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .realign  (realign),
    .bitLast  (bitLast),
    .slotLast (slotLast),
    .strb     (strb)
  );

  e1_seq_datapath #(
    .BITS_PER_SLOT   (BITS_PER_SLOT),
    .SLOTS_PER_FRAME (SLOTS_PER_FRAME),
    .FRAMES_PER_MF   (FRAMES_PER_MF),
    .SIG_SLOT        (SIG_SLOT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .bitLast    (bitLast),
    .slotLast   (slotLast),
    .bitNum     (bitNum),
    .slotNum    (slotNum),
    .frameNum   (frameNum),
    .chanNum    (chanNum),
    .chanValid  (chanValid),
    .frameStart (frameStart),
    .mfStart    (mfStart),
    .alignSlot  (alignSlot),
    .sigSlot    (sigSlot)
  );

endmodule

// File: tb/sim_e1_slot_seq.sv
`timescale 1ns/1ps
module sim_e1_slot_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       realign = 1'b0;
  logic [3:0] bitNum;
  logic [4:0] slotNum;
  logic [3:0] frameNum;
  logic [4:0] chanNum;
  logic       chanValid, frameStart, mfStart, alignSlot, sigSlot;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  e1_slot_seq u0 (
    .clk(clk), .rst(rst), .realign(realign),
    .bitNum(bitNum), .slotNum(slotNum), .frameNum(frameNum),
    .chanNum(chanNum), .chanValid(chanValid), .frameStart(frameStart),
    .mfStart(mfStart), .alignSlot(alignSlot), .sigSlot(sigSlot)
  );

  // Table columns: cycle, bit, slot, frame, chan, valid, fStart, mStart, align, sig
  localparam int NV = 12;
  localparam int VEC [NV][10] = '{
    '{0,    1, 0,  0, 0,  0, 1, 1, 1, 0},
    '{7,    8, 0,  0, 0,  0, 0, 0, 1, 0},
    '{8,    1, 1,  0, 1,  1, 0, 0, 0, 0},
    '{123,  4, 15, 0, 15, 1, 0, 0, 0, 0},
    '{128,  1, 16, 0, 0,  0, 0, 0, 0, 1},
    '{135,  8, 16, 0, 0,  0, 0, 0, 0, 1},
    '{136,  1, 17, 0, 16, 1, 0, 0, 0, 0},
    '{255,  8, 31, 0, 30, 1, 0, 0, 0, 0},
    '{256,  1, 0,  1, 0,  0, 1, 0, 1, 0},
    '{4095, 8, 31, 15, 30, 1, 0, 0, 0, 0},
    '{4096, 1, 0,  0, 0,  0, 1, 1, 1, 0},
    '{4104, 1, 1,  0, 1,  1, 0, 0, 0, 0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Position model computed from clocks since start
  task automatic checkModel(input int n, input string req);
    int b, s, f, c, v;
    b = n % 8 + 1;
    s = (n / 8) % 32;
    f = (n / 256) % 16;
    v = (s != 0 && s != 16) ? 1 : 0;
    c = (s == 0 || s == 16) ? 0 : (s < 16 ? s : s - 1);
    check(req, "bitNum", int'(bitNum), b);
    check(req, "slotNum", int'(slotNum), s);
    check(req, "frameNum", int'(frameNum), f);
    check(req, "chanNum", int'(chanNum), c);
    check(req, "chanValid", int'(chanValid), v);
    check(req, "frameStart", int'(frameStart), (b == 1 && s == 0) ? 1 : 0);
    check(req, "mfStart", int'(mfStart), (b == 1 && s == 0 && f == 0) ? 1 : 0);
    check(req, "alignSlot", int'(alignSlot), s == 0 ? 1 : 0);
    check(req, "sigSlot", int'(sigSlot), s == 16 ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "bitNum", int'(bitNum), 1);
    check("R1", "slotNum", int'(slotNum), 0);
    check("R1", "frameNum", int'(frameNum), 0);
    rst = 1'b0;

    // Table walk plus model over a full multiframe and a bit more
    for (int n = 0; n <= 4200; n++) begin
      for (int k = 0; k < NV; k++) begin
        if (VEC[k][0] == n) begin
          check("R2", "tbl bitNum", int'(bitNum), VEC[k][1]);
          check("R3", "tbl slotNum", int'(slotNum), VEC[k][2]);
          check("R4", "tbl frameNum", int'(frameNum), VEC[k][3]);
          check("R5_R6", "tbl chanNum", int'(chanNum), VEC[k][4]);
          check("R7", "tbl chanValid", int'(chanValid), VEC[k][5]);
          check("R8", "tbl frameStart", int'(frameStart), VEC[k][6]);
          check("R9", "tbl mfStart", int'(mfStart), VEC[k][7]);
          check("R10", "tbl alignSlot", int'(alignSlot), VEC[k][8]);
          check("R10", "tbl sigSlot", int'(sigSlot), VEC[k][9]);
        end
      end
      checkModel(n, "R2_R10");
      @(negedge clk);
    end

    // R11: realign mid-frame (now at n=4201: frame 0, slot 13)
    realign = 1'b1;
    @(negedge clk);
    realign = 1'b0;
    check("R11", "bitNum", int'(bitNum), 1);
    check("R11", "slotNum", int'(slotNum), 0);
    check("R11", "frameNum", int'(frameNum), 0);
    check("R11", "mfStart", int'(mfStart), 1);
    for (int n = 0; n < 300; n++) begin
      checkModel(n, "R11");
      @(negedge clk);
    end

    // R11: realign held two cycles stays at start
    realign = 1'b1;
    @(negedge clk);
    @(negedge clk);
    realign = 1'b0;
    checkModel(0, "R11");
    @(negedge clk);
    checkModel(1, "R11");

    // R1: reset mid-run returns to start
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkModel(0, "R1");
    for (int n = 1; n < 20; n++) begin
      @(negedge clk);
      checkModel(n, "R1");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule